// File: doc/BRIEF.md
# UART Baud Clock Generator

This block derives the bit-rate timing for a UART from a single peripheral clock. A two-bit source select picks the base tick: one of three fixed power-of-two prescale ratios of the peripheral clock, or a one-cycle tick supplied by an external timer. A five-bit divisor k then counts k base ticks per half period. Every k base ticks the block emits a one-cycle enable pulse and flips a square-wave output. The full output period is therefore 2·k base periods.

Everything runs on the one input clock. The prescaler, the source choice and the divider all produce clock enables, not derived clocks. A divisor below 8 is raised to 8. A new select or divisor is held back until the next half-period boundary, so a half period is never cut short. Dropping the enable clears all state. Raising it again starts counting from zero with the current settings.

Top module: `uart_baud_gen`

## Requirements
- R1: While reset is asserted and after its release with the enable low, `baud_en` and `baud_clk` are 0.
- R2: With `src_sel` = 2'b00 the base tick is the clock divided by 2, and `baud_en` pulses every 2·k clock cycles.
- R3: With `src_sel` = 2'b01 the base tick is the clock divided by 8, and `baud_en` pulses every 8·k clock cycles.
- R4: With `src_sel` = 2'b10 the base tick is the clock divided by 32, and `baud_en` pulses every 32·k clock cycles.
- R5: With `src_sel` = 2'b11 each cycle with `tmr_tick` high counts as one base tick, giving k ticks per half period. Under any other select, `tmr_tick` has no effect on the output timing.
- R6: `baud_en` is high for exactly one cycle. `baud_clk` takes its new level in that same cycle and holds it until the next pulse. The first pulse after enabling drives it to 1.
- R7: A divisor value below 8 (including 0) behaves exactly as k = 8.
- R8: After `en` rises, `baud_en` is first high in the cycle that follows the k·N-th enabled rising clock edge, where N is the base ratio.
- R9: A changed `div_k` or `src_sel` takes effect only at the next half-period boundary. A change presented in the very cycle of that boundary is taken at that boundary.
- R10: When the source changes at a boundary, the following half period is exactly k·N_new cycles, because the prescaler restarts at every boundary.
- R11: When `en` is low, both outputs are 0 from the next cycle on, and timer ticks are ignored. On re-enable, timing restarts as in R8.
- R12: The largest divisor, k = 31, is honoured without truncation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears all counting state |
| src_sel | input | 2 | Base select: 00 = /2, 01 = /8, 10 = /32, 11 = external timer tick |
| div_k | input | 5 | Half-period divisor k, effective range 8..31 |
| tmr_tick | input | 1 | One-cycle tick from an external timer |
| baud_en | output | 1 | One-cycle pulse at every half-period boundary |
| baud_clk | output | 1 | Square-wave baud clock, period 2·k base ticks |

## Verification
Two events can land in the same cycle: the divider wrap, and the arrival of a new divisor or source on the inputs. The bench provokes this by changing `div_k` on the falling edge just before the rising edge it expects to wrap on. It then judges the outcome from two intervals: the half period that ends at that wrap must still use the old k, and the one after it must use the new k. The prescaler restart and a source switch also coincide at a wrap. This is judged by switching from /2 to /8 at a wrap where the free-running prescale count would be misaligned, and requiring the next interval to be exactly 8·k cycles.

// File: rtl/ubg_pkg.sv
package ubg_pkg;

  localparam int SEL_W    = 2;
  localparam int NUM_TAPS = 3;
  localparam int DIV_W    = 5;
  localparam int K_MIN    = 8;

  typedef enum logic [SEL_W-1:0] {
    SRC_DIV2  = 2'd0,
    SRC_DIV8  = 2'd1,
    SRC_DIV32 = 2'd2,
    SRC_TIMER = 2'd3
  } src_e;

  // log2 of the prescale ratio for each fixed tap
  function automatic int tap_log2(input int idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      default: return 5;
    endcase
  endfunction

  // prescaler width covers the widest tap
  localparam int PRE_W = tap_log2(NUM_TAPS - 1);

endpackage

// File: rtl/ubg_prescaler.sv
module ubg_prescaler #(
  parameter int CNT_W = ubg_pkg::PRE_W,
  parameter int TAPS  = ubg_pkg::NUM_TAPS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            restart,
  output logic [TAPS-1:0] tick_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || restart)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + ONE;
  end

  // each tap fires when its low bits are all ones
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    localparam int L = ubg_pkg::tap_log2(i);
    assign tick_o[i] = run && (&cnt_q[L-1:0]);
  end

endmodule

// File: rtl/ubg_cfg.sv
module ubg_cfg #(
  parameter int K_WIDTH = ubg_pkg::DIV_W,
  parameter int K_FLOOR = ubg_pkg::K_MIN,
  parameter int S_WIDTH = ubg_pkg::SEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               load,
  input  logic [S_WIDTH-1:0] sel_i,
  input  logic [K_WIDTH-1:0] k_i,
  output logic [S_WIDTH-1:0] sel_o,
  output logic [K_WIDTH-1:0] k_o
);

  localparam logic [K_WIDTH-1:0] FLOOR_V = K_WIDTH'(K_FLOOR);

  function automatic logic [K_WIDTH-1:0] floor_k(input logic [K_WIDTH-1:0] k);
    return (k < FLOOR_V) ? FLOOR_V : k;
  endfunction

  // settings follow the inputs while idle, otherwise only at a boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o <= '0;
      k_o   <= FLOOR_V;
    end else if (!run || load) begin
      sel_o <= sel_i;
      k_o   <= floor_k(k_i);
    end
  end

endmodule

// File: rtl/ubg_srcsel.sv
module ubg_srcsel #(
  parameter int TAPS    = ubg_pkg::NUM_TAPS,
  parameter int S_WIDTH = ubg_pkg::SEL_W
) (
  input  logic               run,
  input  logic [TAPS-1:0]    tap_i,
  input  logic               ext_i,
  input  logic [S_WIDTH-1:0] sel_i,
  output logic               tick_o
);

  localparam int NSRC = TAPS + 1;

  logic [NSRC-1:0] src_vec;

  assign src_vec = {ext_i, tap_i};
  assign tick_o  = run && src_vec[sel_i];

endmodule

// File: rtl/ubg_divider.sv
module ubg_divider #(
  parameter int K_WIDTH = ubg_pkg::DIV_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick_i,
  input  logic [K_WIDTH-1:0] k_i,
  output logic               wrap_o,
  output logic [K_WIDTH-1:0] cnt_o,
  output logic               level_o,
  output logic               pulse_o
);

  localparam logic [K_WIDTH-1:0] ONE = K_WIDTH'(1);

  function automatic logic [K_WIDTH-1:0] last_index(input logic [K_WIDTH-1:0] k);
    return k - ONE;
  endfunction

  logic [K_WIDTH-1:0] cnt_q;
  logic               level_q;
  logic               pulse_q;

  assign wrap_o = run && tick_i && (cnt_q == last_index(k_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else if (!run) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap_o;
      if (tick_i)
        cnt_q <= wrap_o ? '0 : cnt_q + ONE;
      if (wrap_o)
        level_q <= ~level_q;
    end
  end

  assign cnt_o   = cnt_q;
  assign level_o = level_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen #(
  parameter int K_WIDTH = ubg_pkg::DIV_W,
  parameter int K_FLOOR = ubg_pkg::K_MIN
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [ubg_pkg::SEL_W-1:0] src_sel,
  input  logic [K_WIDTH-1:0]        div_k,
  input  logic                      tmr_tick,
  output logic                      baud_en,
  output logic                      baud_clk
);

  localparam int TAPS = ubg_pkg::NUM_TAPS;
  localparam int SW   = ubg_pkg::SEL_W;

  // named internal events, observed by the bound checker
  logic [TAPS-1:0]    pre_tick;
  logic               base_tick;
  logic               wrap_evt;
  logic [K_WIDTH-1:0] div_cnt;
  logic [K_WIDTH-1:0] act_k;
  logic [SW-1:0]      act_sel;

  ubg_prescaler #(.CNT_W(ubg_pkg::PRE_W), .TAPS(TAPS)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .restart (wrap_evt),
    .tick_o  (pre_tick)
  );

  ubg_cfg #(.K_WIDTH(K_WIDTH), .K_FLOOR(K_FLOOR), .S_WIDTH(SW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en),
    .load  (wrap_evt),
    .sel_i (src_sel),
    .k_i   (div_k),
    .sel_o (act_sel),
    .k_o   (act_k)
  );

  ubg_srcsel #(.TAPS(TAPS), .S_WIDTH(SW)) u_src (
    .run    (en),
    .tap_i  (pre_tick),
    .ext_i  (tmr_tick),
    .sel_i  (act_sel),
    .tick_o (base_tick)
  );

  ubg_divider #(.K_WIDTH(K_WIDTH)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (en),
    .tick_i  (base_tick),
    .k_i     (act_k),
    .wrap_o  (wrap_evt),
    .cnt_o   (div_cnt),
    .level_o (baud_clk),
    .pulse_o (baud_en)
  );

endmodule

// File: rtl/ubg_checker.sv
module ubg_checker #(
  parameter int K_WIDTH = 5,
  parameter int K_FLOOR = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               en,
  input logic               tmr_tick,
  input logic               baud_en,
  input logic               baud_clk,
  input logic               base_tick,
  input logic               wrap_evt,
  input logic [K_WIDTH-1:0] div_cnt,
  input logic [K_WIDTH-1:0] act_k,
  input logic [1:0]         act_sel
);

  localparam logic [K_WIDTH-1:0] FLOOR_V = K_WIDTH'(K_FLOOR);

  assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < act_k);

  assert_timer_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && act_sel == ubg_pkg::SRC_TIMER) |-> tmr_tick);

  assert_pulse_toggles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |-> (baud_clk != $past(baud_clk)));

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |=> !baud_en);

  assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_evt) |=> $stable(baud_clk));

  assert_k_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_k >= FLOOR_V);

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_evt) |=> ($stable(act_k) && $stable(act_sel)));

  assert_off_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!baud_clk && !baud_en));

  assert_off_no_tick_R11: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> en);

endmodule

bind uart_baud_gen ubg_checker #(.K_WIDTH(K_WIDTH), .K_FLOOR(K_FLOOR)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .tmr_tick  (tmr_tick),
  .baud_en   (baud_en),
  .baud_clk  (baud_clk),
  .base_tick (base_tick),
  .wrap_evt  (wrap_evt),
  .div_cnt   (div_cnt),
  .act_k     (act_k),
  .act_sel   (act_sel)
);

// File: tb/uart_baud_gen_tb.sv
`timescale 1ns/1ps
module uart_baud_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [1:0] src_sel = 2'b00;
  logic [4:0] div_k = 5'd8;
  logic       tmr_tick = 1'b0;
  logic       baud_en;
  logic       baud_clk;

  int n_chk = 0;
  int n_fail = 0;
  int tper = 0;
  int tcnt = 0;

  always #2 clk = ~clk;

  uart_baud_gen dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .src_sel  (src_sel),
    .div_k    (div_k),
    .tmr_tick (tmr_tick),
    .baud_en  (baud_en),
    .baud_clk (baud_clk)
  );

  // external timer model: one tick every tper cycles, none when tper is 0
  always @(negedge clk) begin
    if (tper == 0) begin
      tmr_tick <= 1'b0;
      tcnt     <= 0;
    end else if (tcnt >= tper - 1) begin
      tmr_tick <= 1'b1;
      tcnt     <= 0;
    end else begin
      tmr_tick <= 1'b0;
      tcnt     <= tcnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // count falling edges until baud_en is seen high
  task automatic meas(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!baud_en && n < 5000);
  endtask

  // clear, load settings while idle, then enable
  task automatic start(input logic [1:0] s, input logic [4:0] k);
    @(negedge clk);
    en = 1'b0;
    src_sel = s;
    div_k = k;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic t_reset();
    chk(baud_en == 1'b0 && baud_clk == 1'b0, "R1 in reset",
        {baud_en, baud_clk}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(baud_en == 1'b0 && baud_clk == 1'b0, "R1 idle after reset",
        {baud_en, baud_clk}, 0);
  endtask

  task automatic t_rate(input logic [1:0] s, input logic [4:0] k_in,
                        input int k_eff, input int ratio, input string req);
    int n;
    start(s, k_in);
    meas(n);
    chk(n == k_eff * ratio, {req, " R8 first pulse"}, n, k_eff * ratio);
    chk(baud_clk == 1'b1, {req, " R6 level after first pulse"}, baud_clk, 1);
    meas(n);
    chk(n == k_eff * ratio, {req, " half period"}, n, k_eff * ratio);
    chk(baud_clk == 1'b0, {req, " R6 level after second pulse"}, baud_clk, 0);
    meas(n);
    chk(n == k_eff * ratio, {req, " half period repeat"}, n, k_eff * ratio);
  endtask

  task automatic t_timer();
    int n;
    tper = 3;
    start(2'b11, 5'd9);
    meas(n);
    chk(n >= 25 && n <= 30, "R5 first timer half", n, 27);
    meas(n);
    chk(n == 27, "R5 timer half period", n, 27);
    meas(n);
    chk(n == 27, "R5 timer half period repeat", n, 27);
    tper = 0;
    n = 0;
    repeat (300) begin
      @(negedge clk);
      if (baud_en) n++;
    end
    chk(n == 0, "R5 no ticks no pulses", n, 0);
  endtask

  task automatic t_defer();
    int n;
    start(2'b00, 5'd10);
    meas(n);
    div_k = 5'd12;
    meas(n);
    chk(n == 20, "R9 old divisor kept", n, 20);
    meas(n);
    chk(n == 24, "R9 new divisor applied", n, 24);
    n = 0;
    repeat (23) begin
      @(negedge clk);
      if (baud_en) n++;
    end
    chk(n == 0, "R9 no early pulse", n, 0);
    div_k = 5'd9;
    @(negedge clk);
    chk(baud_en == 1'b1, "R9 same-cycle change keeps boundary", baud_en, 1);
    meas(n);
    chk(n == 18, "R9 same-cycle change taken", n, 18);
  endtask

  task automatic t_switch();
    int n;
    start(2'b00, 5'd9);
    meas(n);
    src_sel = 2'b01;
    meas(n);
    chk(n == 18, "R10 old source kept", n, 18);
    meas(n);
    chk(n == 72, "R10 switched to /8", n, 72);
    src_sel = 2'b10;
    meas(n);
    chk(n == 72, "R10 /8 kept until boundary", n, 72);
    meas(n);
    chk(n == 288, "R10 switched to /32", n, 288);
    src_sel = 2'b00;
    meas(n);
    meas(n);
    chk(n == 18, "R10 switched back to /2", n, 18);
  endtask

  task automatic t_disable();
    int n;
    start(2'b01, 5'd8);
    meas(n);
    repeat (10) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(baud_clk == 1'b0 && baud_en == 1'b0, "R11 outputs cleared",
        {baud_en, baud_clk}, 0);
    src_sel = 2'b11;
    tper = 1;
    n = 0;
    repeat (100) begin
      @(negedge clk);
      if (baud_en || baud_clk) n++;
    end
    chk(n == 0, "R11 timer ignored while off", n, 0);
    tper = 0;
    src_sel = 2'b01;
    @(negedge clk);
    en = 1'b1;
    meas(n);
    chk(n == 64, "R11 restart from zero", n, 64);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    t_rate(2'b00, 5'd10, 10, 2, "R2");
    tper = 2;
    t_rate(2'b01, 5'd9, 9, 8, "R3 R5 timer ignored");
    tper = 0;
    t_rate(2'b10, 5'd8, 8, 32, "R4");
    t_rate(2'b00, 5'd31, 31, 2, "R12");
    t_rate(2'b00, 5'd3, 8, 2, "R7 k=3");
    t_rate(2'b01, 5'd0, 8, 8, "R7 k=0");
    t_timer();
    t_defer();
    t_switch();
    t_disable();
    summary();
    $finish;
  end

  initial begin
    #600000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule